// File: doc/BRIEF.md
# Interrupt Line State Register Bank

This block keeps the per-line state of a group of external interrupt lines for an interrupt controller: an enable bit, a pending bit and an active bit for every line. Software reaches it through a small word-addressed register space. Enable and pending each have two addresses. Writing ones to one address sets the selected bits, and writing ones to the other clears them. A third kind of write pends a single line by its number. A rising edge on a hardware interrupt input pends the line whether or not it is enabled. A line can therefore hold pending and active at once: inactive, pending, active, or pending-and-active.

An arbiter outside this block chooses which line to take. It sees the pending and enable vectors, then signals an acknowledge with a line number. The acknowledge moves that line from pending to active. When the handler finishes, a completion strobe retires the line that is currently running. The block records which line each acknowledge interrupted. Nested handlers therefore unwind in order, and the summary word always names the line that is really running.

The summary word is read-only. It reports three things: the vector number of the running line, the vector number of the lowest-numbered line that is both pending and enabled, and a flag that is set when no more than one line is active. Vector numbers are the line number plus a fixed base.

Top module: `irq_state_bank`

## Requirements
- R1: A write to region 0 (enable-set) sets every enable bit whose data bit is 1, and a write to region 1 (enable-clear) clears them. Data bits that are 0 change nothing. Reading either region returns the enable bits.
- R2: Regions 2 (pending-set) and 3 (pending-clear) act on the pending bits in the same way, and reading either region returns the pending bits.
- R3: A rising edge on an interrupt input sets that line's pending bit even while the line is disabled. A disabled pending line is left out of the summary word. Once the line is enabled, the summary word reports it.
- R4: A write to region 6 (software trigger) whose data bits 8:0 hold a line number below the line count sets that line's pending bit. Larger numbers have no effect.
- R5: An acknowledge clears the line's pending bit and sets its active bit on the same clock edge. Region 4 reads the active bits, and writes to region 4 are ignored.
- R6: If a line's input rises again while the line is active, the line becomes pending and active. A later completion leaves it pending only.
- R7: A completion clears the active bit of the running line. The running line then becomes the line that its acknowledge interrupted, or none if it interrupted nothing.
- R8: The summary word is read at region 5, word 0. Bits 7:0 hold the running line plus the vector base. Bits 20:12 hold the lowest line that is both pending and enabled, plus the vector base. Each field is 0 when there is no such line. All other bits read 0.
- R9: Summary bit 11 is 1 when at most one line is active, and 0 otherwise.
- R10: When one clock edge both sets and clears a pending bit, the set wins. The set may come from an input edge, a pending-set write or a software trigger. The clear may come from a pending-clear write or an acknowledge.
- R11: The address is the region in the top 3 bits followed by the word index. Line k is bit k mod 32 of word k/32. Bits and words beyond the line count read 0, and so does region 7.
- R12: After reset, all enable, pending and active bits are 0, no line is running, and the summary word reads 0x800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_LINES | Interrupt inputs; a rising edge pends the line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address: region in the top 3 bits, word index below |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read address, same layout as wr_addr |
| rd_data | output | 32 | Combinational read data |
| ack_valid | input | 1 | Arbiter acknowledge strobe |
| ack_line | input | LW | Line being acknowledged |
| done_valid | input | 1 | Completion of the running line |
| pend_lines | output | N_LINES | Pending bits, for the arbiter |
| en_lines | output | N_LINES | Enable bits, for the arbiter |

## Verification
The bench builds the block with 40 lines and a vector base of 16. This gives two register words, and the second word holds only eight real lines. With that setting the bench can reach the word-index decoding, the bits that must read 0 past the last line, and software-trigger numbers between 40 and 63 that must be ignored. It also covers nesting across both words, for example line 5 interrupted by line 35, with a summary field value above 32.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the interrupt line state bank: register region
// codes and the bit positions of the summary word.
package irq_bank_pkg;
    typedef enum logic [2:0] {
        RG_EN_SET  = 3'd0,
        RG_EN_CLR  = 3'd1,
        RG_PD_SET  = 3'd2,
        RG_PD_CLR  = 3'd3,
        RG_ACTIVE  = 3'd4,
        RG_STATUS  = 3'd5,
        RG_SWTRIG  = 3'd6,
        RG_NONE    = 3'd7
    } region_e;

    localparam int unsigned WORD_BITS  = 32;
    localparam int unsigned RUN_LSB    = 0;
    localparam int unsigned RUN_W      = 8;
    localparam int unsigned BASE_BIT   = 11;
    localparam int unsigned PEND_LSB   = 12;
    localparam int unsigned PEND_W     = 9;
endpackage

// File: rtl/irq_edge_det.sv
`timescale 1ns/1ps
// Rising-edge detector for the interrupt inputs.
// Assumes the inputs are already synchronous to clk.
module irq_edge_det #(
    parameter int unsigned N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    output logic [N_LINES-1:0] rise
);
    logic [N_LINES-1:0] irq_q;

    // Keep the previous input level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_in;
    end

    assign rise = irq_in & ~irq_q;
endmodule

// File: rtl/irq_line_bank.sv
`timescale 1ns/1ps
// Per-line enable, pending and active flops with their set and clear
// decode. On a pending bit a set beats a clear. Assumes an acknowledge
// and a completion never target the same line on one edge.
module irq_line_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned LW      = 5,
    parameter int unsigned WIDX_W  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  region_e            wr_region,
    input  logic [WIDX_W-1:0]  wr_widx,
    input  logic [31:0]        wr_data,
    input  logic [N_LINES-1:0] rise,
    input  logic               ack_valid,
    input  logic [LW-1:0]      ack_line,
    input  logic               done_valid,
    input  logic [LW-1:0]      done_line,
    output logic [N_LINES-1:0] en_q,
    output logic [N_LINES-1:0] pend_q,
    output logic [N_LINES-1:0] act_q,
    output logic [N_LINES-1:0] pend_set
);
    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        localparam int unsigned WI = k / WORD_BITS;
        localparam int unsigned BI = k % WORD_BITS;
        logic bit_on, s_pd, c_pd, ack_hit, done_hit;
        logic en_r, pd_r, ac_r;

        assign bit_on   = wr_en && (32'(wr_widx) == WI) && wr_data[BI];
        assign s_pd     = rise[k] || (bit_on && wr_region == RG_PD_SET)
                       || (wr_en && wr_region == RG_SWTRIG && wr_data[8:0] == 9'(k));
        assign ack_hit  = ack_valid && (ack_line == LW'(k));
        assign done_hit = done_valid && (done_line == LW'(k));
        assign c_pd     = (bit_on && wr_region == RG_PD_CLR) || ack_hit;

        // Update this line's three state bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_r <= 1'b0;
                pd_r <= 1'b0;
                ac_r <= 1'b0;
            end else begin
                if (bit_on && wr_region == RG_EN_SET)      en_r <= 1'b1;
                else if (bit_on && wr_region == RG_EN_CLR) en_r <= 1'b0;
                if (s_pd)      pd_r <= 1'b1;
                else if (c_pd) pd_r <= 1'b0;
                if (ack_hit)       ac_r <= 1'b1;
                else if (done_hit) ac_r <= 1'b0;
            end
        end

        assign en_q[k]     = en_r;
        assign pend_q[k]   = pd_r;
        assign act_q[k]    = ac_r;
        assign pend_set[k] = s_pd;
    end
endmodule

// File: rtl/irq_nest_track.sv
`timescale 1ns/1ps
// Tracks the running line and, for each line, the line it interrupted.
// This forms a linked list that a completion unwinds one step at a time.
// Assumes the arbiter never acknowledges a line that is already active.
module irq_nest_track #(
    parameter int unsigned LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_valid,
    input  logic [LW-1:0] ack_line,
    input  logic          done_valid,
    output logic          cur_valid,
    output logic [LW-1:0] cur_line,
    output logic          base_flag
);
    localparam int unsigned DEPTH = 1 << LW;

    logic [DEPTH-1:0] ret_valid;
    logic [LW-1:0]    ret_line [DEPTH];

    // Push on acknowledge, pop on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid <= 1'b0;
            cur_line  <= '0;
            ret_valid <= '0;
            for (int i = 0; i < int'(DEPTH); i++) ret_line[i] <= '0;
        end else if (ack_valid) begin
            ret_valid[ack_line] <= cur_valid;
            ret_line[ack_line]  <= cur_line;
            cur_valid           <= 1'b1;
            cur_line            <= ack_line;
        end else if (done_valid) begin
            cur_valid <= ret_valid[cur_line];
            cur_line  <= ret_line[cur_line];
        end
    end

    // Nothing is active beneath the running line.
    assign base_flag = !cur_valid || !ret_valid[cur_line];
endmodule

// File: rtl/irq_status_sum.sv
`timescale 1ns/1ps
// Builds the read-only summary word from the running line, the nesting
// flag and the lowest line that is both pending and enabled.
module irq_status_sum
    import irq_bank_pkg::*;
#(
    parameter int unsigned N_LINES  = 32,
    parameter int unsigned LW       = 5,
    parameter int unsigned VEC_BASE = 16
) (
    input  logic [N_LINES-1:0] en_q,
    input  logic [N_LINES-1:0] pend_q,
    input  logic               cur_valid,
    input  logic [LW-1:0]      cur_line,
    input  logic               base_flag,
    output logic [31:0]        status
);
    logic          found;
    logic [LW-1:0] low_idx;

    // Scan downward so the lowest qualifying line is the last one stored.
    always_comb begin
        found   = 1'b0;
        low_idx = '0;
        for (int i = int'(N_LINES) - 1; i >= 0; i--) begin
            if (pend_q[i] && en_q[i]) begin
                found   = 1'b1;
                low_idx = LW'(i);
            end
        end
    end

    // Pack the summary fields.
    always_comb begin
        status = '0;
        if (cur_valid) status[RUN_LSB +: RUN_W] = RUN_W'(cur_line) + RUN_W'(VEC_BASE);
        if (found)     status[PEND_LSB +: PEND_W] = PEND_W'(low_idx) + PEND_W'(VEC_BASE);
        status[BASE_BIT] = base_flag;
    end
endmodule

// File: rtl/irq_state_bank.sv
`timescale 1ns/1ps
// Top of the interrupt line state bank. It decodes the word-addressed
// register space, instantiates the line state, the nesting tracker and
// the summary logic, and drives the combinational read mux. It assumes the
// external arbiter only acknowledges a line that is pending and not
// active, and never acknowledges and completes on the same cycle.
module irq_state_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned N_LINES  = 32,
    parameter int unsigned VEC_BASE = 16,
    localparam int unsigned LW      = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int unsigned WORDS   = (N_LINES + WORD_BITS - 1) / WORD_BITS,
    localparam int unsigned WIDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int unsigned AW      = 3 + WIDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [31:0]        rd_data,
    input  logic               ack_valid,
    input  logic [LW-1:0]      ack_line,
    input  logic               done_valid,
    output logic [N_LINES-1:0] pend_lines,
    output logic [N_LINES-1:0] en_lines
);
    localparam int unsigned PAD_W = WORDS * WORD_BITS;

    region_e            wr_region, rd_region;
    logic [WIDX_W-1:0]  wr_widx, rd_widx;
    logic [N_LINES-1:0] rise, en_q, pend_q, act_q, pend_set;
    logic               cur_valid, base_flag;
    logic [LW-1:0]      cur_line;
    logic [31:0]        status_w;
    logic [PAD_W-1:0]   en_pad, pend_pad, act_pad;

    assign wr_region = region_e'(wr_addr[AW-1 -: 3]);
    assign wr_widx   = wr_addr[WIDX_W-1:0];
    assign rd_region = region_e'(rd_addr[AW-1 -: 3]);
    assign rd_widx   = rd_addr[WIDX_W-1:0];

    irq_edge_det #(.N_LINES(N_LINES)) u_edge (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise)
    );

    irq_line_bank #(.N_LINES(N_LINES), .LW(LW), .WIDX_W(WIDX_W)) u_lines (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_region(wr_region),
        .wr_widx(wr_widx), .wr_data(wr_data), .rise(rise),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .done_valid(done_valid), .done_line(cur_line),
        .en_q(en_q), .pend_q(pend_q), .act_q(act_q), .pend_set(pend_set)
    );

    irq_nest_track #(.LW(LW)) u_nest (
        .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_line(ack_line),
        .done_valid(done_valid), .cur_valid(cur_valid), .cur_line(cur_line),
        .base_flag(base_flag)
    );

    irq_status_sum #(.N_LINES(N_LINES), .LW(LW), .VEC_BASE(VEC_BASE)) u_sum (
        .en_q(en_q), .pend_q(pend_q), .cur_valid(cur_valid),
        .cur_line(cur_line), .base_flag(base_flag), .status(status_w)
    );

    assign en_pad   = PAD_W'(en_q);
    assign pend_pad = PAD_W'(pend_q);
    assign act_pad  = PAD_W'(act_q);

    // Select the addressed word; unmapped words and regions read zero.
    always_comb begin
        rd_data = '0;
        if (32'(rd_widx) < WORDS) begin
            case (rd_region)
                RG_EN_SET, RG_EN_CLR: rd_data = en_pad[32'(rd_widx) * WORD_BITS +: WORD_BITS];
                RG_PD_SET, RG_PD_CLR: rd_data = pend_pad[32'(rd_widx) * WORD_BITS +: WORD_BITS];
                RG_ACTIVE:            rd_data = act_pad[32'(rd_widx) * WORD_BITS +: WORD_BITS];
                RG_STATUS:            if (rd_widx == '0) rd_data = status_w;
                default:              rd_data = '0;
            endcase
        end
    end

    assign pend_lines = pend_q;
    assign en_lines   = en_q;
endmodule

// File: rtl/irq_state_bank_chk.sv
`timescale 1ns/1ps
// Property checker for irq_state_bank. It relates the line state bits,
// the nesting tracker and the summary word over time. It is bound into
// every instance of the top.
module irq_state_bank_chk #(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned LW      = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_valid,
    input logic [LW-1:0]      ack_line,
    input logic               done_valid,
    input logic [N_LINES-1:0] pend_set,
    input logic [N_LINES-1:0] pend_q,
    input logic [N_LINES-1:0] act_q,
    input logic               cur_valid,
    input logic [LW-1:0]      cur_line,
    input logic [31:0]        status_w
);
    // R5: an acknowledge names a pending, idle line and never comes with a completion
    p_ack_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (pend_q[ack_line] && !act_q[ack_line] && !done_valid));

    p_ack_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> act_q[$past(ack_line)]);

    p_ack_unpend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !pend_set[ack_line]) |=> !pend_q[$past(ack_line)]);

    p_done_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> cur_valid);

    p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !act_q[$past(cur_line)]);

    p_run_is_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid |-> act_q[cur_line]);

    p_base_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_w[11] == ($countones(act_q) <= 1));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_set) |=> ((pend_q & $past(pend_set)) == $past(pend_set)));
endmodule

bind irq_state_bank irq_state_bank_chk #(.N_LINES(N_LINES), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_line(ack_line),
    .done_valid(done_valid), .pend_set(pend_set), .pend_q(pend_q),
    .act_q(act_q), .cur_valid(cur_valid), .cur_line(cur_line),
    .status_w(status_w)
);

// File: tb/tb_irq_state_bank.sv
`timescale 1ns/1ps
// Bench for irq_state_bank: a behavioural reference model is updated on
// every clock edge and compared with the ports on every cycle. Directed
// steps and a random phase drive the design.
module tb_irq_state_bank;
    localparam int NL = 40;
    localparam int VB = 16;
    localparam int LW = 6;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic          ack_valid = 1'b0;
    logic [LW-1:0] ack_line = '0;
    logic          done_valid = 1'b0;
    logic [NL-1:0] pend_lines, en_lines;

    int n_chk = 0, n_fail = 0, rot = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    irq_state_bank #(.N_LINES(NL), .VEC_BASE(VB)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ack_valid(ack_valid), .ack_line(ack_line),
        .done_valid(done_valid), .pend_lines(pend_lines), .en_lines(en_lines)
    );

    // ---------------- reference model ----------------
    bit m_en[NL], m_pend[NL], m_act[NL], m_prev[NL];
    int stk[$];

    always @(posedge clk) begin
        int rg, w;
        bit wbit, sp, cp;
        if (!rst_n) begin
            for (int k = 0; k < NL; k++) begin
                m_en[k] = 0; m_pend[k] = 0; m_act[k] = 0; m_prev[k] = 0;
            end
            stk.delete();
        end else begin
            rg = int'(wr_addr[AW-1 -: 3]);
            w  = int'(wr_addr[0]);
            for (int k = 0; k < NL; k++) begin
                wbit = wr_en && (k / 32 == w) && wr_data[k % 32];
                sp = (irq_in[k] && !m_prev[k]) || (wbit && rg == 2)
                     || (wr_en && rg == 6 && int'(wr_data[8:0]) == k);
                cp = (wbit && rg == 3) || (ack_valid && int'(ack_line) == k);
                if (wbit && rg == 0) m_en[k] = 1;
                else if (wbit && rg == 1) m_en[k] = 0;
                if (sp) m_pend[k] = 1;
                else if (cp) m_pend[k] = 0;
                m_prev[k] = irq_in[k];
            end
            if (ack_valid) begin
                m_act[ack_line] = 1;
                stk.push_back(int'(ack_line));
            end else if (done_valid && stk.size() > 0) begin
                m_act[stk[$]] = 0;
                void'(stk.pop_back());
            end
        end
    end

    function automatic logic [31:0] m_status();
        int lo = -1, cnt = 0;
        logic [31:0] s = '0;
        for (int k = 0; k < NL; k++) begin
            if (m_pend[k] && m_en[k] && lo < 0) lo = k;
            if (m_act[k]) cnt++;
        end
        if (stk.size() > 0) s[7:0] = 8'(stk[$] + VB);
        if (lo >= 0) s[20:12] = 9'(lo + VB);
        s[11] = (cnt <= 1);
        return s;
    endfunction

    // which: 0 enable, 1 pending, 2 active
    function automatic logic [31:0] m_word(int which, int w);
        logic [31:0] r = '0;
        for (int b = 0; b < 32; b++) begin
            int k = w * 32 + b;
            if (k < NL) r[b] = (which == 0) ? m_en[k] : (which == 1) ? m_pend[k] : m_act[k];
        end
        return r;
    endfunction

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input int rg, input int w, input logic [31:0] exp, input string tag);
        rd_addr = {3'(rg), 1'(w)};
        #1;
        chk(tag, {32'd0, rd_data}, {32'd0, exp});
    endtask

    task automatic compare_all();
        logic [NL-1:0] ep, ee;
        for (int k = 0; k < NL; k++) begin ep[k] = m_pend[k]; ee[k] = m_en[k]; end
        chk("R2 pend_lines port", 64'(pend_lines), 64'(ep));
        chk("R1 en_lines port", 64'(en_lines), 64'(ee));
        if (rot < 10) begin
            int rg = rot % 5, w = rot / 5;
            case (rg)
                0, 1:    rd_chk(rg, w, m_word(0, w), "R1 enable word");
                2, 3:    rd_chk(rg, w, m_word(1, w), "R2 pending word");
                default: rd_chk(rg, w, m_word(2, w), "R5 active word");
            endcase
        end else if (rot == 10) rd_chk(5, 0, m_status(), "R8 summary word");
        else if (rot == 11)     rd_chk(7, 0, 32'd0, "R11 region 7");
        else                    rd_chk(5, 1, 32'd0, "R11 summary word 1");
        rot = (rot + 1) % 13;
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
        wr_en = 0; ack_valid = 0; done_valid = 0;
    endtask

    task automatic wr(input int rg, input int w, input logic [31:0] d);
        wr_en = 1; wr_addr = {3'(rg), 1'(w)}; wr_data = d;
        tick();
    endtask

    task automatic do_ack(input int line);
        ack_valid = 1; ack_line = LW'(line);
        tick();
    endtask

    task automatic do_done();
        done_valid = 1;
        tick();
    endtask

    task automatic set_irq(input int k, input bit v);
        irq_in[k] = v;
        tick();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        rd_chk(5, 0, 32'h800, "R12 reset summary");
        rd_chk(0, 0, 32'h0, "R12 reset enable");
        rd_chk(4, 1, 32'h0, "R12 reset active");

        wr(0, 0, 32'h8);
        wr(0, 1, 32'h8);
        rd_chk(1, 0, 32'h8, "R1 enable via clear address");
        rd_chk(0, 1, 32'h8, "R11 line 35 in word 1 bit 3");
        wr(0, 0, 32'h0);
        rd_chk(0, 0, 32'h8, "R1 zero bits ignored");
        wr(1, 0, 32'h8);
        rd_chk(0, 0, 32'h0, "R1 enable clear");

        set_irq(5, 1);
        rd_chk(2, 0, 32'h20, "R3 pend while disabled");
        rd_chk(5, 0, 32'h800, "R3 disabled line not reported");
        wr(0, 0, 32'h20);
        rd_chk(5, 0, (21 << 12) | 32'h800, "R3 R8 reported once enabled");

        wr(6, 0, 32'd35);
        rd_chk(2, 1, 32'h8, "R4 trigger line 35");
        wr(6, 0, 32'd45);
        rd_chk(3, 1, 32'h8, "R4 number past line count ignored");
        rd_chk(3, 0, 32'h20, "R4 word 0 untouched");

        do_ack(5);
        rd_chk(2, 0, 32'h0, "R5 ack clears pending");
        rd_chk(4, 0, 32'h20, "R5 ack sets active");
        rd_chk(5, 0, 21 | 32'h800 | (51 << 12), "R8 running and pending fields");
        wr(4, 0, 32'hFFFF_FFFF);
        rd_chk(4, 0, 32'h20, "R5 active region write ignored");

        set_irq(5, 0);
        set_irq(5, 1);
        rd_chk(2, 0, 32'h20, "R6 pending while active");
        rd_chk(4, 0, 32'h20, "R6 still active");

        do_ack(35);
        rd_chk(5, 0, 51 | (21 << 12), "R9 nested: flag 0, running 51");
        rd_chk(4, 1, 32'h8, "R7 line 35 active");
        do_done();
        rd_chk(5, 0, 21 | 32'h800 | (21 << 12), "R7 back to line 5, R9 flag 1");
        do_done();
        rd_chk(4, 0, 32'h0, "R7 nothing active");
        rd_chk(2, 0, 32'h20, "R6 falls back to pending");
        rd_chk(5, 0, 32'h800 | (21 << 12), "R8 running field 0");

        set_irq(5, 0);
        irq_in[5] = 1; ack_valid = 1; ack_line = 6'd5;
        tick();
        rd_chk(2, 0, 32'h20, "R10 edge beats ack clear");
        rd_chk(4, 0, 32'h20, "R10 ack still activates");
        do_done();

        irq_in[7] = 1; wr(3, 0, 32'hA0);
        rd_chk(2, 0, 32'h80, "R10 edge beats clear write; R2 bit 5 cleared");
        wr(2, 1, 32'h80);
        rd_chk(3, 1, 32'h80, "R2 set line 39");
        wr(2, 1, 32'hFFFF_FF00);
        rd_chk(2, 1, 32'h80, "R11 bits past line count read 0");
        rd_chk(7, 1, 32'h0, "R11 region 7 word 1");

        // random phase
        for (int c = 0; c < 3000; c++) begin
            int r = int'($urandom % 8);
            if ($urandom % 2 == 0) irq_in[$urandom % NL] ^= 1'b1;
            if (r < 4) begin
                wr_en = 1;
                wr_addr = AW'($urandom);
                wr_data = (wr_addr[AW-1 -: 3] == 3'd6) ? 32'($urandom % 64) : $urandom;
            end
            if (r >= 4 && r < 6) begin
                int pick = -1;
                for (int k = 0; k < NL; k++)
                    if (pick < 0 && m_pend[k] && m_en[k] && !m_act[k]) pick = k;
                if (pick >= 0) begin ack_valid = 1; ack_line = LW'(pick); end
            end else if (r >= 6 && stk.size() > 0) begin
                done_valid = 1;
            end
            tick();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule